// File: doc/BRIEF.md
# Processor Mode Status Register

This block holds the status word of a processor core. The word carries four condition flags, two interrupt-disable bits, a state bit and a five-bit operating-mode field. Five exception modes each have a saved copy of the status word. User and System have none, because they share one register set and differ only in privilege. The mode field uses a sparse encoding. The block decodes it into one-hot mode lines and detects values that name no mode. An illegal mode value puts the block into a lockup state that only reset clears.

The surrounding core drives single-cycle strobes:
- An exception-entry strobe with a target mode saves the live status into that mode's saved copy and switches mode on the same clock edge.
- A return strobe reloads the live status from the current mode's saved copy.
- A software write carries a byte mask. It goes to the live status word or to the saved copy of the current mode.

Bit positions with no defined field are never stored and always read as zero.

Top module: `mode_status_reg`

## Requirements
- R1: After reset `status` reads 0x000000D3: mode Supervisor, both interrupt-disable bits set, flags and state bit clear. `saved_rd` reads 0, `mode_oh` reads 7'b0001000 and `lockup` is 0. All saved copies reset to 0.
- R2: The mode field is `status[4:0]`. `mode_oh` has bit 0 User (10000), bit 1 FIQ (10001), bit 2 IRQ (10010), bit 3 Supervisor (10011), bit 4 Abort (10111), bit 5 Undefined (11011) and bit 6 System (11111). Exactly one bit is high for a legal mode.
- R3: When the stored mode field holds any other value, `lockup` reads 1 and `mode_oh` reads 0 from the next clock edge. Both stay that way until reset.
- R4: While `lockup` is 1, writes, exception entries and returns have no effect on `status` or on any saved copy.
- R5: A live write (`wr_en`=1, `wr_sel`=0) updates fields according to `wr_mask`. Mask bit 3 loads `status[31:28]` from `wr_data[31:28]`. Mask bit 0 loads `status[7:0]` (bit 7 IRQ disable, bit 6 FIQ disable, bit 5 state, bits 4:0 mode). Mask bits 1 and 2 do nothing. `status[27:8]` always reads 0.
- R6: In User mode a live write updates only the flags. The control byte (`status[7:0]`) is left unchanged.
- R7: An exception entry (`exc_req`=1 with `exc_mode` FIQ, IRQ, Supervisor, Abort or Undefined) copies the current status into that mode's saved copy. In the same edge it loads `exc_mode` into the mode field and leaves the other bits unchanged. An `exc_mode` of User, System or an illegal value makes the request ignored.
- R8: `saved_rd` shows the saved copy of the current mode, laid out like `status`. It reads 0 in User mode, in System mode and in lockup.
- R9: A return (`ret_req`=1) loads `status` from the current mode's saved copy. It is ignored in User and System modes.
- R10: A saved-copy write (`wr_en`=1, `wr_sel`=1) applies the R5 masks to the current mode's saved copy. It is ignored in User and System modes.
- R11: Strobes take effect in this priority order: `exc_req`, then `ret_req`, then `wr_en`. A lower-priority strobe is ignored whenever a higher one is high, even if the higher one is itself ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the exception entry |
| ret_req | input | 1 | Exception-return strobe |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write target: 0 live status, 1 saved copy of current mode |
| wr_mask | input | 4 | Byte mask of the write |
| wr_data | input | 32 | Write data |
| status | output | 32 | Live status word |
| saved_rd | output | 32 | Saved copy of the current mode |
| mode_oh | output | 7 | One-hot decoded mode |
| lockup | output | 1 | Illegal-mode lockup indicator |

## Verification
A wrong internal state in this block shows up at the ports one clock edge after the stimulus that caused it:
- A corrupt mode field changes `mode_oh` and `lockup` at once.
- A misdirected save, or a save into the wrong slot, appears on `saved_rd` as soon as the mode selecting that slot is entered. It also appears in the live word after the next return.
- A failure to freeze during lockup appears as a change on `status` one edge after a blocked request.

The stimulus therefore walks through every mode and returns through saved copies that earlier steps wrote. It also drives illegal modes in by both a direct write and a return.

// File: rtl/mode_status_reg.sv
module mode_status_reg #(
  parameter int NSAVED = 5,
  parameter int MW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic [MW-1:0] exc_mode,
  input  logic          ret_req,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [3:0]    wr_mask,
  input  logic [31:0]   wr_data,
  output logic [31:0]   status,
  output logic [31:0]   saved_rd,
  output logic [6:0]    mode_oh,
  output logic          lockup
);
  localparam int SW = 12;
  localparam int IW = $clog2(NSAVED + 1);
  localparam logic [IW-1:0] NONE = IW'(NSAVED);
  localparam logic [MW-1:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                            M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                            M_SYS = 5'b11111;
  localparam logic [7:0] CTRL_RST = {3'b110, M_SVC};

  function automatic logic [IW-1:0] slot_of(input logic [MW-1:0] m);
    case (m)
      M_FIQ:   slot_of = IW'(0);
      M_IRQ:   slot_of = IW'(1);
      M_SVC:   slot_of = IW'(2);
      M_ABT:   slot_of = IW'(3);
      M_UND:   slot_of = IW'(4);
      default: slot_of = NONE;
    endcase
  endfunction

  function automatic logic [31:0] widen(input logic [SW-1:0] w);
    widen = {w[11:8], 20'b0, w[7:0]};
  endfunction

  logic [3:0]    flags_q;
  logic [7:0]    ctrl_q;
  logic [SW-1:0] saved_q [NSAVED];
  logic [SW-1:0] saved_sel;

  wire [MW-1:0] cur_mode = ctrl_q[MW-1:0];
  wire [IW-1:0] cur_slot = slot_of(cur_mode);
  wire [IW-1:0] tgt_slot = slot_of(exc_mode);
  wire          has_saved = cur_slot != NONE;

  assign mode_oh = {cur_mode == M_SYS, cur_mode == M_UND, cur_mode == M_ABT,
                    cur_mode == M_SVC, cur_mode == M_IRQ, cur_mode == M_FIQ,
                    cur_mode == M_USR};
  assign lockup = ~|mode_oh;

  wire do_exc = exc_req && !lockup && tgt_slot != NONE;
  wire do_ret = ret_req && !exc_req && !lockup && has_saved;
  wire do_wr  = wr_en && !exc_req && !ret_req && !lockup;
  wire priv   = !mode_oh[0];

  always_comb begin
    saved_sel = '0;
    for (int i = 0; i < NSAVED; i++)
      if (cur_slot == IW'(i)) saved_sel = saved_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ctrl_q  <= CTRL_RST;
    end else if (do_exc) begin
      ctrl_q[MW-1:0] <= exc_mode;
    end else if (do_ret) begin
      flags_q <= saved_sel[11:8];
      ctrl_q  <= saved_sel[7:0];
    end else if (do_wr && !wr_sel) begin
      if (wr_mask[3]) flags_q <= wr_data[31:28];
      if (wr_mask[0] && priv) ctrl_q <= wr_data[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSAVED; i++) saved_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSAVED; i++) begin
        if (do_exc && tgt_slot == IW'(i)) begin
          saved_q[i] <= {flags_q, ctrl_q};
        end else if (do_wr && wr_sel && cur_slot == IW'(i)) begin
          if (wr_mask[3]) saved_q[i][11:8] <= wr_data[31:28];
          if (wr_mask[0]) saved_q[i][7:0]  <= wr_data[7:0];
        end
      end
    end
  end

  assign status   = widen({flags_q, ctrl_q});
  assign saved_rd = (has_saved && !lockup) ? widen(saved_sel) : '0;

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mode_oh));
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n) lockup |=> lockup);
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> ($stable(status) && $stable(saved_rd)));
  a_r6_user_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockup && mode_oh[0] && !exc_req) |=> status[7:0] == $past(status[7:0]));
  a_r7_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !lockup && tgt_slot != NONE) |=>
      (status[4:0] == $past(exc_mode) && saved_rd == $past(status)));
  a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !exc_req && !lockup && has_saved) |=> status == $past(saved_rd));
endmodule

// File: tb/mode_status_reg_tb.sv
module mode_status_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic exc_req = 0, ret_req = 0, wr_en = 0, wr_sel = 0;
  logic [4:0] exc_mode = '0;
  logic [3:0] wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status, saved_rd;
  logic [6:0] mode_oh;
  logic lockup;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] st;
    logic [31:0] sr;
    logic [6:0]  oh;
    logic        lk;
    string       tag;
  } exp_t;
  exp_t q[$];

  mode_status_reg u_dut (.clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_mode(exc_mode),
    .ret_req(ret_req), .wr_en(wr_en), .wr_sel(wr_sel), .wr_mask(wr_mask), .wr_data(wr_data),
    .status(status), .saved_rd(saved_rd), .mode_oh(mode_oh), .lockup(lockup));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input exp_t e);
    checks++;
    if (status !== e.st) begin failures++;
      $display("FAIL %s status act=%h exp=%h", e.tag, status, e.st); end
    checks++;
    if (saved_rd !== e.sr) begin failures++;
      $display("FAIL %s saved_rd act=%h exp=%h", e.tag, saved_rd, e.sr); end
    checks++;
    if (mode_oh !== e.oh) begin failures++;
      $display("FAIL %s mode_oh act=%b exp=%b", e.tag, mode_oh, e.oh); end
    checks++;
    if (lockup !== e.lk) begin failures++;
      $display("FAIL %s lockup act=%b exp=%b", e.tag, lockup, e.lk); end
  endtask

  always @(negedge clk) if (q.size() > 0) check(q.pop_front());

  task automatic step(input logic e, input logic [4:0] em, input logic r, input logic w,
                      input logic ws, input logic [3:0] m, input logic [31:0] d,
                      input logic [31:0] est, input logic [31:0] esr, input logic [6:0] eoh,
                      input logic elk, input string tag);
    exp_t x;
    @(negedge clk);
    exc_req = e; exc_mode = em; ret_req = r; wr_en = w; wr_sel = ws; wr_mask = m; wr_data = d;
    @(posedge clk);
    #1;
    exc_req = 0; ret_req = 0; wr_en = 0; wr_sel = 0;
    x.st = est; x.sr = esr; x.oh = eoh; x.lk = elk; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    exp_t r;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    r.st = 32'h000000D3; r.sr = 0; r.oh = 7'b0001000; r.lk = 0; r.tag = "R1 reset";
    check(r);
    step(0,0,0,1,0,4'b1000,32'hFFFFFFFF, 32'hF00000D3,0,7'h08,0,"R5 flag write");
    step(0,0,0,1,0,4'b0110,32'hFFFFFFFF, 32'hF00000D3,0,7'h08,0,"R5 reserved mask");
    step(0,0,0,1,1,4'b1001,32'hA5A5A5B7, 32'hF00000D3,32'hA00000B7,7'h08,0,"R10 saved write");
    step(1,5'h12,0,0,0,0,0, 32'hF00000D2,32'hF00000D3,7'h04,0,"R7 entry irq");
    step(1,5'h1F,0,0,0,0,0, 32'hF00000D2,32'hF00000D3,7'h04,0,"R7 sys target ignored");
    step(1,5'h17,1,1,0,4'b1111,0, 32'hF00000D7,32'hF00000D2,7'h10,0,"R11 exc wins");
    step(0,0,1,1,0,4'b1000,0, 32'hF00000D2,32'hF00000D3,7'h04,0,"R9 R11 ret wins");
    step(0,0,0,1,0,4'b0001,32'h000000D1, 32'hF00000D1,0,7'h02,0,"R2 fiq");
    step(0,0,0,1,0,4'b0001,32'h000000DB, 32'hF00000DB,0,7'h20,0,"R2 und");
    step(0,0,0,1,0,4'b0001,32'h000000DF, 32'hF00000DF,0,7'h40,0,"R8 sys no saved");
    step(0,0,0,1,1,4'b1111,32'hFFFFFFFF, 32'hF00000DF,0,7'h40,0,"R10 sys saved ignored");
    step(0,0,1,0,0,0,0, 32'hF00000DF,0,7'h40,0,"R9 sys ret ignored");
    step(0,0,0,1,0,4'b0001,32'h00000010, 32'hF0000010,0,7'h01,0,"R2 user");
    step(0,0,0,1,0,4'b1001,32'h500000DF, 32'h50000010,0,7'h01,0,"R6 user ctrl ignored");
    step(0,0,0,1,1,4'b1111,32'hFFFFFFFF, 32'h50000010,0,7'h01,0,"R10 user saved ignored");
    step(1,5'h13,0,0,0,0,0, 32'h50000013,32'h50000010,7'h08,0,"R7 entry svc");
    step(0,0,1,0,0,0,0, 32'h50000010,0,7'h01,0,"R9 return to user");
    step(1,5'h1B,0,0,0,0,0, 32'h5000001B,32'h50000010,7'h20,0,"R7 entry und");
    step(0,0,0,1,1,4'b0001,32'h00000014, 32'h5000001B,32'h50000014,7'h20,0,"R10 und saved");
    step(0,0,1,0,0,0,0, 32'h50000014,0,7'h00,1,"R3 illegal via return");
    step(0,0,0,1,0,4'b1111,32'h000000D3, 32'h50000014,0,7'h00,1,"R4 write blocked");
    step(1,5'h13,0,0,0,0,0, 32'h50000014,0,7'h00,1,"R4 entry blocked");
    step(0,0,0,0,0,0,0, 32'h50000014,0,7'h00,1,"R3 sticky");
    @(negedge clk);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    r.st = 32'h000000D3; r.sr = 0; r.oh = 7'b0001000; r.lk = 0; r.tag = "R1 second reset";
    check(r);
    step(0,0,0,1,0,4'b0001,32'h00000000, 32'h00000000,0,7'h00,1,"R3 illegal via write");
    step(0,0,1,0,0,0,0, 32'h00000000,0,7'h00,1,"R4 return blocked");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      finish_run();
    end
  end
endmodule